// File: doc/BRIEF.md
# Timer-Clocked Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that runs only the variable-rate, 10-bit character format: one low start bit, eight data bits sent least significant bit first, and one high stop bit. It has no baud generator of its own. An external timer delivers one-cycle overflow pulses. The block divides these pulses by a prescale factor to make a 16x oversampling tick, and then by 16 again to make the bit tick. With the default values the bit rate is the overflow rate divided by 32. For example, a 921.6 kHz machine-cycle rate and a timer reload of 0xFD give 9600 baud. A reload of 0xF4 gives 2400 baud, and 0xE8 gives 1200 baud.

Software sees two byte-wide locations, chosen by one select bit. Location 0 is the control byte. Location 1 is the data buffer. A write to the buffer queues a character for transmission. A read of the buffer returns the most recently accepted received byte. The control byte holds the two format bits, the receive enable, and two sticky completion flags. Hardware sets the flags and software clears them. The interrupt output is the OR of the two flags.

Top module: `ser10_port`

## Requirements
- R1: The transmit line idles high. Each character appears on it as a low start bit, then data bits 0 through 7 in that order, then a high stop bit.
- R2: Every bit on the transmit line lasts exactly 16 x PRESCALE overflow pulses. With the default PRESCALE of 2 that is 32 pulses, so one pulse every N clocks gives a bit of 32 x N clocks.
- R3: The transmit flag (control bit 1) stays clear while the last data bit is on the line. It becomes 1 when the stop bit starts.
- R4: While receive is enabled, a well-formed character arriving on the receive line is stored in the buffer (location 1). The receive flag (control bit 0) then becomes 1, and bit 0 of the buffer is the first data bit received.
- R5: While the receive enable (control bit 4) is 0, characters on the receive line leave the receive flag and the buffer unchanged.
- R6: A falling edge whose line is high again at the middle of the start bit is rejected. No flag is set, and a character that follows is still received correctly.
- R7: A character that completes while the receive flag is already 1 is dropped. The buffer keeps its earlier value.
- R8: The control byte reads back bits 7:6 (format, where 01 selects this mode), bit 4 (receive enable), bit 1 (transmit flag) and bit 0 (receive flag). Bits 5, 3 and 2 read as 0, so writing 0xFF reads back 0xD3. Writing 0 to a flag clears it.
- R9: The interrupt output is 1 exactly when at least one of the two flags is 1.
- R10: After reset the transmit line is high, the interrupt output is 0, and both the control byte and the buffer read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovf_i | input | 1 | One-cycle overflow pulse from the external timer |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = control byte, 1 = data buffer |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| irq_o | output | 1 | Interrupt request: OR of the two flags |

## Verification
The bench builds the block with its default values: PRESCALE 2 and 16x oversampling. In most runs the timer input is held high on every clock, so a bit takes 32 clocks and a full frame about 320. Because a frame is this short, the transmit line can be looped back to the receive line and all 256 byte values can be sent and received. Each value is checked as it leaves on the line and again as it arrives in the buffer. Single runs with a slower overflow rate measure the bit length. Frames driven directly on the receive line cover the rejected start, a character sent with receive disabled, and a character that arrives while the receive flag is still set.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

    localparam int DATA_W   = 8;
    localparam int LAST_IDX = DATA_W + 1;   // index of the stop bit within a frame

    // control byte bit positions
    localparam int CB_FMT_HI = 7;
    localparam int CB_FMT_LO = 6;
    localparam int CB_REN    = 4;
    localparam int CB_TXF    = 1;
    localparam int CB_RXF    = 0;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] fmt;
        logic       ren;
        logic       txf;
        logic       rxf;
    } ctrl_t;

    function automatic logic [7:0] ctrl_pack(ctrl_t c);
        logic [7:0] b;
        b = '0;
        b[CB_FMT_HI:CB_FMT_LO] = c.fmt;
        b[CB_REN] = c.ren;
        b[CB_TXF] = c.txf;
        b[CB_RXF] = c.rxf;
        return b;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [7:0] b);
        ctrl_t c;
        c.fmt = b[CB_FMT_HI:CB_FMT_LO];
        c.ren = b[CB_REN];
        c.txf = b[CB_TXF];
        c.rxf = b[CB_RXF];
        return c;
    endfunction

endpackage

// File: rtl/ser10_prescale.sv
module ser10_prescale #(
    parameter int PRESCALE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ovf_i,
    output logic os_tick_o
);
    logic tick_q;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam int CW = $clog2(PRESCALE);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    tick_q <= 1'b0;
                    if (ovf_i) begin
                        if (cnt_q == CW'(PRESCALE - 1)) begin
                            cnt_q  <= '0;
                            tick_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            end

            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick_q |=> !tick_q);
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) tick_q <= 1'b0;
                else     tick_q <= ovf_i;
            end
        end
    endgenerate

    assign os_tick_o = tick_q;

endmodule

// File: rtl/ser10_tx.sv
module ser10_tx
    import ser10_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              txd_o,
    output logic              done_o
);
    localparam int PW = $clog2(OVS);
    localparam int IW = $clog2(LAST_IDX + 1);

    logic [PW-1:0]     ph_q;
    logic              bit_tick;
    logic              pend_q, busy_q, txd_q, done_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W:0]   sh_q;
    logic [IW-1:0]     idx_q;

    assign bit_tick = os_tick_i && (ph_q == PW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
            done_q <= 1'b0;
            hold_q <= '0;
            sh_q   <= '1;
            idx_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (os_tick_i) ph_q <= (ph_q == PW'(OVS - 1)) ? '0 : ph_q + 1'b1;

            if (bit_tick) begin
                if (busy_q && idx_q != IW'(LAST_IDX)) begin
                    txd_q <= sh_q[0];
                    sh_q  <= {1'b1, sh_q[DATA_W:1]};
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IW'(LAST_IDX - 1)) done_q <= 1'b1;
                end else if (pend_q) begin
                    // start bit, back to back with a finished frame if queued
                    txd_q  <= 1'b0;
                    sh_q   <= {1'b1, hold_q};
                    idx_q  <= '0;
                    busy_q <= 1'b1;
                    pend_q <= 1'b0;
                end else begin
                    busy_q <= 1'b0;
                end
            end

            if (wr_i) begin
                pend_q <= 1'b1;
                hold_q <= data_i;
            end
        end
    end

    assign txd_o  = txd_q;
    assign done_o = done_q;

    // R1
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q == IW'(LAST_IDX)) |-> txd_q);

    // R3
    done_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (busy_q && idx_q == IW'(LAST_IDX) && txd_q));

endmodule

// File: rtl/ser10_rx.sv
module ser10_rx
    import ser10_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick_i,
    input  logic              en_i,
    input  logic              rxd_i,
    input  logic              flag_i,
    output logic              load_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              set_o
);
    localparam int PW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int NW   = $clog2(DATA_W);

    rx_state_e         state_q;
    logic              s1_q, s2_q, prev_q;
    logic [PW-1:0]     cnt_q;
    logic [NW-1:0]     nbit_q;
    logic [DATA_W-1:0] sh_q, byte_q;
    logic              keep_q, load_q, set_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            prev_q  <= 1'b1;
            cnt_q   <= '0;
            nbit_q  <= '0;
            sh_q    <= '0;
            byte_q  <= '0;
            keep_q  <= 1'b0;
            load_q  <= 1'b0;
            set_q   <= 1'b0;
        end else begin
            s1_q   <= rxd_i;
            s2_q   <= s1_q;
            load_q <= 1'b0;
            set_q  <= 1'b0;
            if (os_tick_i) begin
                prev_q <= s2_q;
                cnt_q  <= cnt_q + 1'b1;
                unique case (state_q)
                    RX_IDLE: begin
                        if (prev_q && !s2_q) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == PW'(HALF - 1)) begin
                            cnt_q  <= '0;
                            nbit_q <= '0;
                            state_q <= s2_q ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == PW'(OVS - 1)) begin
                            cnt_q  <= '0;
                            sh_q   <= {s2_q, sh_q[DATA_W-1:1]};
                            nbit_q <= nbit_q + 1'b1;
                            if (nbit_q == NW'(DATA_W - 1)) begin
                                state_q <= RX_STOP;
                                byte_q  <= {s2_q, sh_q[DATA_W-1:1]};
                                load_q  <= !flag_i;
                                keep_q  <= !flag_i;
                            end
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == PW'(OVS - 1)) begin
                            state_q <= RX_IDLE;
                            set_q   <= keep_q;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
            if (!en_i) state_q <= RX_IDLE;
        end
    end

    assign load_o = load_q;
    assign byte_o = byte_q;
    assign set_o  = set_q;

    // R5
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (state_q == RX_IDLE));

    // R7
    no_clobber_chk: assert property (@(posedge clk) disable iff (rst)
        load_q |-> $past(!flag_i));

    // R4
    set_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        set_q |-> keep_q);

endmodule

// File: rtl/ser10_port.sv
module ser10_port
    import ser10_pkg::*;
#(
    parameter int PRESCALE = 2,
    parameter int OVS      = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ovf_i,
    input  logic       reg_we_i,
    input  logic       reg_sel_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       txd_o,
    input  logic       rxd_i,
    output logic       irq_o
);
    logic              os_tick;
    logic              tx_done, rx_load, rx_set;
    logic [DATA_W-1:0] rx_byte;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] rbuf_q;

    ser10_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst(rst), .ovf_i(ovf_i), .os_tick_o(os_tick)
    );

    ser10_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .os_tick_i(os_tick),
        .wr_i(reg_we_i && reg_sel_i), .data_i(reg_wdata_i),
        .txd_o(txd_o), .done_o(tx_done)
    );

    ser10_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .os_tick_i(os_tick), .en_i(ctrl_q.ren),
        .rxd_i(rxd_i), .flag_i(ctrl_q.rxf),
        .load_o(rx_load), .byte_o(rx_byte), .set_o(rx_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (reg_we_i && !reg_sel_i) ctrl_q <= ctrl_unpack(reg_wdata_i);
            if (tx_done) ctrl_q.txf <= 1'b1;
            if (rx_set)  ctrl_q.rxf <= 1'b1;
            if (rx_load) rbuf_q <= rx_byte;
        end
    end

    assign reg_rdata_o = reg_sel_i ? rbuf_q : ctrl_pack(ctrl_q);
    assign irq_o       = ctrl_q.txf | ctrl_q.rxf;

    // R4
    buf_update_chk: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> (rbuf_q == $past(rx_byte)));

    // R3
    txf_set_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> ctrl_q.txf);

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.rxf) |-> irq_o);

endmodule

// File: tb/ser10_port_tb.sv
module ser10_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovf = 1'b0;
    logic       we = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd;
    logic       rxd;
    logic       irq;
    logic       loop_en = 1'b0;
    logic       rxd_drv = 1'b1;
    int         tick_per = 1;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done_flag = 1'b0;

    assign rxd = loop_en ? txd : rxd_drv;

    ser10_port dut_i (
        .clk(clk), .rst(rst), .ovf_i(ovf), .reg_we_i(we), .reg_sel_i(sel),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .txd_o(txd), .rxd_i(rxd),
        .irq_o(irq)
    );

    always #4 clk = ~clk;

    // timer overflow source: one pulse every tick_per clocks
    initial begin
        int tc;
        tc = 0;
        forever begin
            @(negedge clk);
            ovf = (tc == 0);
            tc  = (tc + 1 >= tick_per) ? 0 : tc + 1;
        end
    end

    function automatic int bitp();
        return 32 * tick_per;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] d);
        sel = s;
        #1;
        d = rdata;
    endtask

    // capture one transmitted frame; also read transmit flag at bit 7 and stop
    task automatic tx_cap(output logic [9:0] fr, output logic f7, output logic fs);
        logic [7:0] c;
        int guard;
        guard = 0;
        @(negedge clk);
        while (txd !== 1'b0 && guard < 4 * bitp()) begin
            @(negedge clk);
            guard++;
        end
        repeat (bitp() / 2) @(negedge clk);
        fr[0] = txd;
        for (int i = 1; i < 10; i++) begin
            repeat (bitp()) @(negedge clk);
            fr[i] = txd;
            if (i == 8) begin rd(1'b0, c); f7 = c[1]; end
            if (i == 9) begin rd(1'b0, c); fs = c[1]; end
        end
    endtask

    task automatic wait_rxf(input int maxc, output logic got);
        logic [7:0] c;
        got = 1'b0;
        for (int i = 0; i < maxc && !got; i++) begin
            @(negedge clk);
            rd(1'b0, c);
            got = c[0];
        end
    endtask

    task automatic drive_frame(input logic [7:0] b);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rxd_drv = fr[i];
            repeat (bitp()) @(negedge clk);
        end
        rxd_drv = 1'b1;
    endtask

    task automatic start_len(output int len);
        len = 0;
        wr(1'b1, 8'hFF);
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0 && len < 10000) begin
            @(negedge clk);
            len++;
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [9:0] fr;
        logic       f7, fs, got;
        int         len;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 txd", 32'(txd), 32'd1);
        chk("R10 irq", 32'(irq), 32'd0);
        rd(1'b0, v); chk("R10 ctrl", 32'(v), 32'h00);
        rd(1'b1, v); chk("R10 buf", 32'(v), 32'h00);

        // R8 control layout, R9 interrupt OR
        wr(1'b0, 8'hFF); rd(1'b0, v); chk("R8 ctrl FF", 32'(v), 32'hD3);
        chk("R9 irq both", 32'(irq), 32'd1);
        wr(1'b0, 8'h02); rd(1'b0, v); chk("R8 ctrl 02", 32'(v), 32'h02);
        chk("R9 irq txf", 32'(irq), 32'd1);
        wr(1'b0, 8'h01); chk("R9 irq rxf", 32'(irq), 32'd1);
        wr(1'b0, 8'h00); rd(1'b0, v); chk("R8 clear", 32'(v), 32'h00);
        chk("R9 irq none", 32'(irq), 32'd0);

        // R2 bit length at two overflow rates
        tick_per = 3;
        repeat (8) @(negedge clk);
        start_len(len); chk("R2 bit len N=3", 32'(len), 32'd96);
        repeat (12 * bitp()) @(negedge clk);
        tick_per = 1;
        repeat (8) @(negedge clk);
        start_len(len); chk("R2 bit len N=1", 32'(len), 32'd32);
        repeat (12 * bitp()) @(negedge clk);

        // R1 R3 R4 loopback sweep over every byte value
        loop_en = 1'b1;
        wr(1'b0, 8'h50);
        for (int b = 0; b < 256; b++) begin
            wr(1'b1, 8'(b));
            tx_cap(fr, f7, fs);
            chk("R1 frame", 32'(fr), 32'({1'b1, 8'(b), 1'b0}));
            chk("R3 txf at bit7", 32'(f7), 32'd0);
            chk("R3 txf at stop", 32'(fs), 32'd1);
            wait_rxf(2 * bitp(), got);
            chk("R4 rxf", 32'(got), 32'd1);
            rd(1'b1, v); chk("R4 buf", 32'(v), 32'(b));
            wr(1'b0, 8'h50);
        end
        chk("R9 irq cleared", 32'(irq), 32'd0);
        repeat (bitp()) @(negedge clk);

        // R7 overrun: leave flag set, a new byte is dropped
        wr(1'b0, 8'h51);
        wr(1'b1, 8'h3C);
        tx_cap(fr, f7, fs);
        repeat (2 * bitp()) @(negedge clk);
        rd(1'b1, v); chk("R7 buf kept", 32'(v), 32'hFF);
        rd(1'b0, v); chk("R7 rxf still", 32'(v[0]), 32'd1);

        // R5 receive disabled
        wr(1'b0, 8'h40);
        wr(1'b1, 8'hA5);
        tx_cap(fr, f7, fs);
        repeat (2 * bitp()) @(negedge clk);
        rd(1'b0, v); chk("R5 rxf", 32'(v[0]), 32'd0);
        rd(1'b1, v); chk("R5 buf", 32'(v), 32'hFF);

        // R6 false start, then a real frame
        loop_en = 1'b0;
        rxd_drv = 1'b1;
        wr(1'b0, 8'h50);
        repeat (bitp()) @(negedge clk);
        rxd_drv = 1'b0;
        repeat (6) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (12 * bitp()) @(negedge clk);
        rd(1'b0, v); chk("R6 no flag", 32'(v[0]), 32'd0);
        rd(1'b1, v); chk("R6 buf kept", 32'(v), 32'hFF);
        drive_frame(8'h96);
        wait_rxf(2 * bitp(), got);
        chk("R6 recover flag", 32'(got), 32'd1);
        rd(1'b1, v); chk("R6 recover buf", 32'(v), 32'h96);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule